// File: doc/BRIEF.md
# Receive-Space Flow Control Unit

This unit manages hardware handshaking for a serial port. It watches how full the local receive queue is and drives the outgoing active-low request-to-send line. It also turns the incoming active-low clear-to-send line into a permit signal that lets the transmitter start a character. Queue storage, bit shifting and modem-status reporting sit in neighbouring blocks.

In automatic mode, the request line has hysteresis on the number of free receive entries. The unit asks for data once more than two entries are free. It withdraws the request when no entry is free. Between those points it keeps its previous state. The clear-to-send input is asynchronous, so it passes through a synchroniser chain before it gates the transmitter.

In manual mode, the request line follows a bit that software writes, and the transmitter is always permitted. This lets software drive a modem directly.

Top module: `afc_unit`

## Requirements
- R1: While reset is asserted and after it is released, `rts_n_o` is 1 (no request). Every synchroniser flop resets to 1 (clear-to-send inactive), so `tx_permit_o` is 0 in automatic mode until a low `cts_n_i` has passed through the synchroniser.
- R2: With `auto_en_i`=1, when free entries (DEPTH − `rx_level_i`) are more than 2 at a rising clock edge, `rts_n_o` is 0 after that edge.
- R3: With `auto_en_i`=1, when free entries are 0 (`rx_level_i` = DEPTH) at a rising edge, `rts_n_o` is 1 after that edge.
- R4: With `auto_en_i`=1, when free entries are 1 or 2 at a rising edge, `rts_n_o` keeps the value it had before that edge, whether that value is 0 or 1.
- R5: A `rx_level_i` greater than DEPTH counts as zero free entries, so in automatic mode `rts_n_o` becomes 1.
- R6: With `auto_en_i`=0, `rts_n_o` after each rising edge equals the inverse of `sw_rts_i` sampled at that edge (`sw_rts_i`=1 means request, line low), whatever the value of `rx_level_i`.
- R7: With `auto_en_i`=1, `tx_permit_o` is 1 exactly when the value of `cts_n_i` sampled SYNC_STAGES rising edges earlier is 0. With the default of 2 stages, a change in `cts_n_i` shows at `tx_permit_o` after the second rising edge.
- R8: With `auto_en_i`=0, `tx_permit_o` is 1 regardless of `cts_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en_i | input | 1 | 1 selects automatic flow control, 0 selects manual (software) control |
| sw_rts_i | input | 1 | Software request value used in manual mode; 1 drives the line low |
| rx_level_i | input | LVL_W | Current receive queue occupancy in entries |
| cts_n_i | input | 1 | Asynchronous active-low clear-to-send from the far end |
| rts_n_o | output | 1 | Active-low request-to-send to the far end |
| tx_permit_o | output | 1 | 1 when the transmitter may start a character |

## Verification
On every cycle, the assertions check the three threshold rules for the request state: set above two free entries, clear at zero free entries, and hold inside the band. They also check that manual mode copies the software bit one edge later. The bench scenarios are needed to show the hysteresis from both directions. Each band value is approached once from an asserted request and once from a withdrawn one. The scenarios also show the clamp for an occupancy above the depth, the reset state, the exact two-edge delay from clear-to-send to permit, and that clear-to-send is ignored in manual mode.

// File: rtl/afc_pkg.sv
package afc_pkg;

   // next-state choice for the request flop
   typedef enum logic [1:0] {
      RTS_KEEP  = 2'd0,
      RTS_RAISE = 2'd1,
      RTS_DROP  = 2'd2,
      RTS_SOFT  = 2'd3
   } rts_action_e;

endpackage

// File: rtl/afc_free_calc.sv
module afc_free_calc #(
   parameter int DEPTH = 16,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic [LVL_W-1:0] level_i,
   output logic [LVL_W-1:0] free_o
);

   localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

   if (DEPTH < 4) begin : g_depth_bad
      $error("afc_free_calc: DEPTH must be at least 4");
   end
   if ((1 << LVL_W) <= DEPTH) begin : g_width_bad
      $error("afc_free_calc: LVL_W too narrow for DEPTH");
   end

   // an occupancy beyond the depth saturates to no free space
   always_comb begin
      if (level_i >= DEPTH_L) free_o = '0;
      else                    free_o = DEPTH_L - level_i;
   end

endmodule

// File: rtl/afc_rts_hyst.sv
module afc_rts_hyst
   import afc_pkg::*;
#(
   parameter int LVL_W     = 5,
   parameter int ON_ABOVE  = 2,
   parameter int OFF_BELOW = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_i,
   input  logic             sw_req_i,
   input  logic [LVL_W-1:0] free_i,
   output logic             req_o
);

   localparam logic [LVL_W-1:0] ON_L  = LVL_W'(ON_ABOVE);
   localparam logic [LVL_W-1:0] OFF_L = LVL_W'(OFF_BELOW);

   if (OFF_BELOW < 1) begin : g_off_bad
      $error("afc_rts_hyst: OFF_BELOW must be at least 1");
   end
   if (OFF_BELOW > ON_ABOVE) begin : g_band_bad
      $error("afc_rts_hyst: OFF_BELOW must not exceed ON_ABOVE");
   end

   rts_action_e act;
   logic        req_q;

   always_comb begin
      if (!auto_i)            act = RTS_SOFT;
      else if (free_i > ON_L) act = RTS_RAISE;
      else if (free_i < OFF_L) act = RTS_DROP;
      else                    act = RTS_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else begin
         unique case (act)
            RTS_RAISE: req_q <= 1'b1;
            RTS_DROP:  req_q <= 1'b0;
            RTS_SOFT:  req_q <= sw_req_i;
            default:   req_q <= req_q;
         endcase
      end
   end

   assign req_o = req_q;

   // R2
   rts_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_i && free_i > ON_L) |=> req_o);

   // R3
   rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_i && free_i == '0) |=> !req_o);

   // R4
   rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_i && free_i >= OFF_L && free_i <= ON_L) |=> $stable(req_o));

   // R6
   rts_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_i) |=> (req_o == $past(sw_req_i)));

endmodule

// File: rtl/afc_cts_sync.sv
module afc_cts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n_i,
   output logic sync_n_o
);

   if (STAGES < 2) begin : g_stages_bad
      $error("afc_cts_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= async_n_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign sync_n_o = chain[STAGES-1];

endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate (
   input  logic auto_i,
   input  logic cts_n_sync_i,
   output logic permit_o
);

   always_comb begin
      if (auto_i) permit_o = ~cts_n_sync_i;
      else        permit_o = 1'b1;
   end

endmodule

// File: rtl/afc_unit.sv
module afc_unit #(
   parameter int DEPTH       = 16,
   parameter int ON_ABOVE    = 2,
   parameter int OFF_BELOW   = 1,
   parameter int SYNC_STAGES = 2,
   localparam int LVL_W      = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_en_i,
   input  logic             sw_rts_i,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic             cts_n_i,
   output logic             rts_n_o,
   output logic             tx_permit_o
);

   if (ON_ABOVE >= DEPTH) begin : g_thr_bad
      $error("afc_unit: ON_ABOVE must be below DEPTH");
   end

   logic [LVL_W-1:0] free_cnt;
   logic             req_act;
   logic             cts_n_sync;

   afc_free_calc #(
      .DEPTH (DEPTH),
      .LVL_W (LVL_W)
   ) i_free (
      .level_i (rx_level_i),
      .free_o  (free_cnt)
   );

   afc_rts_hyst #(
      .LVL_W     (LVL_W),
      .ON_ABOVE  (ON_ABOVE),
      .OFF_BELOW (OFF_BELOW)
   ) i_hyst (
      .clk      (clk),
      .rst_n    (rst_n),
      .auto_i   (auto_en_i),
      .sw_req_i (sw_rts_i),
      .free_i   (free_cnt),
      .req_o    (req_act)
   );

   afc_cts_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_n_i (cts_n_i),
      .sync_n_o  (cts_n_sync)
   );

   afc_tx_gate i_gate (
      .auto_i       (auto_en_i),
      .cts_n_sync_i (cts_n_sync),
      .permit_o     (tx_permit_o)
   );

   assign rts_n_o = ~req_act;

   // R5
   level_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en_i && rx_level_i > LVL_W'(DEPTH)) |=> rts_n_o);

endmodule

// File: tb/test_afc_unit.sv
module test_afc_unit;

   localparam int DEPTH = 16;
   localparam int LW    = $clog2(DEPTH + 1);

   typedef struct {
      logic  rts_n;
      logic  permit;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          auto_en = 1'b1;
   logic          sw_rts = 1'b0;
   logic [LW-1:0] level = '0;
   logic          cts_n = 1'b1;
   logic          rts_n;
   logic          permit;

   int   n_vec = 0;
   int   n_bad = 0;
   exp_t sb[$];

   // model state
   logic m_req = 1'b0;
   logic m_s1 = 1'b1;
   logic m_s2 = 1'b1;

   always #10 clk = ~clk;

   afc_unit #(.DEPTH(DEPTH)) i_afc_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .auto_en_i   (auto_en),
      .sw_rts_i    (sw_rts),
      .rx_level_i  (level),
      .cts_n_i     (cts_n),
      .rts_n_o     (rts_n),
      .tx_permit_o (permit)
   );

   task automatic check(input logic act, input logic exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // driver: set inputs at negedge, predict the outputs after the next edge
   task automatic step(input logic a, input logic sw, input int lvl,
                       input logic c, input string tag);
      int   fr;
      exp_t e;
      @(negedge clk);
      auto_en = a; sw_rts = sw; level = LW'(lvl); cts_n = c;
      fr = (lvl >= DEPTH) ? 0 : DEPTH - lvl;
      if (!a)          m_req = sw;
      else if (fr > 2) m_req = 1'b1;
      else if (fr < 1) m_req = 1'b0;
      m_s2 = m_s1;
      m_s1 = c;
      e.rts_n  = ~m_req;
      e.permit = a ? ~m_s2 : 1'b1;
      e.tag    = tag;
      sb.push_back(e);
   endtask

   // monitor: compare a quarter period after each edge
   initial begin
      forever begin
         exp_t e;
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            check(rts_n, e.rts_n, {e.tag, " rts_n"});
            check(permit, e.permit, {e.tag, " tx_permit"});
         end
      end
   end

   initial begin
      #4_000_000;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(rts_n, 1'b1, "R1 rts_n in reset");
      check(permit, 1'b0, "R1 permit in reset");
      rst_n = 1'b1;
      // R1: full queue keeps the request off after release
      step(1, 0, 16, 1, "R1");
      step(1, 0, 16, 1, "R1");
      // R4: band entered from the off state holds it
      step(1, 0, 15, 1, "R4 hold off free1");
      step(1, 0, 14, 1, "R4 hold off free2");
      // R2: more than two free
      step(1, 0, 13, 1, "R2 free3");
      step(1, 0, 0, 1, "R2 free16");
      // R4: band entered from the on state holds it
      step(1, 0, 14, 1, "R4 hold on free2");
      step(1, 0, 15, 1, "R4 hold on free1");
      // R3: no free entry
      step(1, 0, 16, 1, "R3 free0");
      step(1, 0, 15, 1, "R4 hold off again");
      step(1, 0, 13, 1, "R2 free3 again");
      // R5: occupancy above depth
      step(1, 0, 20, 1, "R5 level20");
      step(1, 0, 2, 1, "R2 recover");
      step(1, 0, 31, 1, "R5 level31");
      // R6: manual mode follows software
      step(0, 1, 16, 1, "R6 sw on full");
      step(0, 0, 0, 1, "R6 sw off empty");
      step(0, 1, 31, 1, "R6 sw on over");
      step(0, 0, 16, 1, "R6 sw off full");
      // R7: clear-to-send delay in auto mode
      step(1, 0, 16, 0, "R7 cts low e1");
      step(1, 0, 16, 0, "R7 cts low e2");
      step(1, 0, 16, 0, "R7 cts low e3");
      step(1, 0, 16, 1, "R7 cts high e1");
      step(1, 0, 16, 1, "R7 cts high e2");
      step(1, 0, 16, 0, "R7 cts pulse");
      step(1, 0, 16, 1, "R7 cts pulse e2");
      step(1, 0, 16, 1, "R7 cts pulse e3");
      // R8: manual mode ignores clear-to-send
      step(0, 0, 8, 1, "R8 cts high");
      step(0, 0, 8, 1, "R8 cts high e2");
      step(0, 0, 8, 0, "R8 cts low");
      step(0, 0, 8, 1, "R8 cts high e3");
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule